// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block drives the command bus of one rank of DDR SDRAM once power and clock are stable. On a start request it brings the memory from reset to the idle state. It first holds clock enable low with NOP for a programmable number of cycles, then raises clock enable. It then issues the fixed setup sequence: a precharge of all banks, a load of the extended mode register, a load of the mode register that also resets the DLL, a second precharge of all banks, a programmable number of auto refreshes, and a final load of the mode register without the DLL reset.

Every gap between commands is a parameter counted in clock cycles, and the bus carries NOP in each waiting cycle. A ready flag rises once the last mode register load has settled. A second flag, which permits reads, waits in addition for a DLL lock window counted from the DLL-reset command. The controller that follows may therefore start activating rows at ready and issue reads only at the later flag.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset the block drives cke_o=0 and NOP (cs_no=0, ras_no=1, cas_no=1, we_no=1), with ba_o=0, addr_o=0, ready_o=0 and rd_ok_o=0. This state holds until start_i is sampled high at a rising clock edge.
- R2: After the start edge, cke_o stays 0 with NOP for exactly T_STABLE cycles. Then one cycle of NOP follows with cke_o=1, and cke_o stays 1 from then on.
- R3: The commands follow in this order: precharge-all, extended mode load, mode load with DLL reset, precharge-all, N_REF auto refreshes, final mode load. The pin codes on {cs_no,ras_no,cas_no,we_no} are precharge 0010, auto refresh 0001 and mode load 0000.
- R4: Each precharge-all drives addr_o[10]=1. All other address bits are 0, and ba_o is 0.
- R5: The extended mode load drives ba_o=1 and addr_o[0]=DLL_DIS (0 enables the DLL). It also drives addr_o[1]=DRV_HALF, which selects the reduced output drive. All other address bits are 0.
- R6: Both mode loads drive ba_o=0, addr_o[2:0]=MR_BL, addr_o[3]=MR_BT and addr_o[6:4]=MR_CL. The first load drives addr_o[8]=1 (DLL reset) and the final load drives addr_o[8]=0. All other address bits are 0.
- R7: The next command comes exactly T_RP cycles after a precharge, T_MRD cycles after either mode load, and T_RFC cycles after an auto refresh. Every cycle in between is NOP.
- R8: ready_o rises exactly T_MRD cycles after the final mode load and stays high. From then on the bus carries only NOP with cke_o=1.
- R9: rd_ok_o is high exactly when ready_o is high and at least T_DLL cycles have elapsed since the DLL-reset mode load.
- R10: start_i has no effect once the sequence has begun or has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the sequence (sampled in the reset-idle state only) |
| cke_o | output | 1 | Clock enable to the memory |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | A_W | Address / mode register operand |
| ready_o | output | 1 | Initialization finished |
| rd_ok_o | output | 1 | Reads permitted (DLL lock window elapsed) |

## Verification
On every cycle the assertions check the exact spacing between successive commands and the precharge address pattern. They also check that the bus is quiet while clock enable is low or ready is high, that clock enable and ready never fall back, and that the read flag agrees with a lock counter kept beside the design. The order of the commands, the exact mode and extended mode operand bits, the length of the clock-enable-low window and the insensitivity to start_i during and after the sequence show only in the bench scenarios. There a reference timeline is compared with the bus cycle by cycle, both with a single start pulse and with start_i held high throughout.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STABLE, ST_CKEUP, ST_PRE1, ST_EMRS,
    ST_MRSD, ST_PRE2, ST_REF, ST_MRSF, ST_DONE
  } step_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t cmd_pins(cmd_e c);
    case (c)
      CMD_PRE: return 4'b0010;
      CMD_REF: return 4'b0001;
      CMD_MRS: return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_dll_cnt.sv
module ddr_init_dll_cnt #(
  parameter int T_DLL = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int DW = $clog2(T_DLL + 1);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       cnt_q <= '0;
    else if (start_i)                                  cnt_q <= DW'(1);
    else if (cnt_q != '0 && cnt_q != DW'(T_DLL))       cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == DW'(T_DLL));
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int          A_W     = 12,
  parameter int          BA_W    = 2,
  parameter logic [2:0]  MR_BL   = 3'b010,
  parameter logic        MR_BT   = 1'b0,
  parameter logic [2:0]  MR_CL   = 3'b010,
  parameter logic        DLL_DIS = 1'b0,
  parameter logic        DRV_HALF = 1'b0
) (
  input  step_e            step_i,
  input  logic             fire_i,
  output logic             cke_o,
  output pins_t            pins_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [A_W-1:0]   addr_o
);
  cmd_e cmd;

  always_comb begin
    cke_o  = !(step_i inside {ST_IDLE, ST_STABLE});
    cmd    = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (fire_i) begin
      case (step_i)
        ST_PRE1, ST_PRE2: begin
          cmd        = CMD_PRE;
          addr_o[10] = 1'b1;
        end
        ST_EMRS: begin
          cmd       = CMD_MRS;
          ba_o      = BA_W'(1);
          addr_o[0] = DLL_DIS;
          addr_o[1] = DRV_HALF;
        end
        ST_MRSD, ST_MRSF: begin
          cmd         = CMD_MRS;
          addr_o[2:0] = MR_BL;
          addr_o[3]   = MR_BT;
          addr_o[6:4] = MR_CL;
          addr_o[8]   = (step_i == ST_MRSD);
        end
        ST_REF:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
    pins_o = cmd_pins(cmd);
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int          A_W      = 12,
  parameter int          BA_W     = 2,
  parameter int          T_STABLE = 20000,
  parameter int          T_RP     = 3,
  parameter int          T_MRD    = 2,
  parameter int          T_RFC    = 10,
  parameter int          N_REF    = 2,
  parameter int          T_DLL    = 200,
  parameter logic [2:0]  MR_BL    = 3'b010,
  parameter logic        MR_BT    = 1'b0,
  parameter logic [2:0]  MR_CL    = 3'b010,
  parameter logic        DLL_DIS  = 1'b0,
  parameter logic        DRV_HALF = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             cke_o,
  output logic             cs_no,
  output logic             ras_no,
  output logic             cas_no,
  output logic             we_no,
  output logic [BA_W-1:0]  ba_o,
  output logic [A_W-1:0]   addr_o,
  output logic             ready_o,
  output logic             rd_ok_o
);
  localparam int M1   = (T_STABLE > T_RP)  ? T_STABLE : T_RP;
  localparam int M2   = (T_MRD > T_RFC)    ? T_MRD    : T_RFC;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int RW   = (N_REF > 1) ? $clog2(N_REF) : 1;

  step_e         state_q, state_d;
  logic          fire_q, fire_d;
  logic [RW-1:0] ref_q, ref_d;
  logic          load;
  logic [TW-1:0] dur;
  logic          tmr_zero;
  logic          dll_done;
  pins_t         pins;

  always_comb begin
    state_d = state_q;
    fire_d  = 1'b0;
    ref_d   = ref_q;
    load    = 1'b0;
    dur     = '0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_STABLE;
        load    = 1'b1;
        dur     = TW'(T_STABLE - 1);
      end
      ST_DONE: ;
      default: if (tmr_zero) begin
        load   = 1'b1;
        fire_d = 1'b1;
        case (state_q)
          ST_STABLE: begin state_d = ST_CKEUP; fire_d = 1'b0; end
          ST_CKEUP:  begin state_d = ST_PRE1; dur = TW'(T_RP - 1);  end
          ST_PRE1:   begin state_d = ST_EMRS; dur = TW'(T_MRD - 1); end
          ST_EMRS:   begin state_d = ST_MRSD; dur = TW'(T_MRD - 1); end
          ST_MRSD:   begin state_d = ST_PRE2; dur = TW'(T_RP - 1);  end
          ST_PRE2: begin
            state_d = ST_REF;
            ref_d   = '0;
            dur     = TW'(T_RFC - 1);
          end
          ST_REF: begin
            if (ref_q == RW'(N_REF - 1)) begin
              state_d = ST_MRSF;
              dur     = TW'(T_MRD - 1);
            end else begin
              ref_d = ref_q + 1'b1;
              dur   = TW'(T_RFC - 1);
            end
          end
          default: begin state_d = ST_DONE; fire_d = 1'b0; load = 1'b0; end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
      ref_q   <= ref_d;
    end
  end

  ddr_init_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (dur),
    .zero_o (tmr_zero)
  );

  ddr_init_dll_cnt #(.T_DLL(T_DLL)) u_dll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fire_q && state_q == ST_MRSD),
    .done_o  (dll_done)
  );

  ddr_init_cmd_enc #(
    .A_W(A_W), .BA_W(BA_W), .MR_BL(MR_BL), .MR_BT(MR_BT),
    .MR_CL(MR_CL), .DLL_DIS(DLL_DIS), .DRV_HALF(DRV_HALF)
  ) u_enc (
    .step_i (state_q),
    .fire_i (fire_q),
    .cke_o  (cke_o),
    .pins_o (pins),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  assign cs_no   = pins.cs_n;
  assign ras_no  = pins.ras_n;
  assign cas_no  = pins.cas_n;
  assign we_no   = pins.we_n;
  assign ready_o = (state_q == ST_DONE);
  assign rd_ok_o = ready_o && dll_done;
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int A_W   = 12,
  parameter int BA_W  = 2,
  parameter int T_RP  = 3,
  parameter int T_MRD = 2,
  parameter int T_RFC = 10,
  parameter int T_DLL = 200
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_o,
  input logic            cs_no,
  input logic            ras_no,
  input logic            cas_no,
  input logic            we_no,
  input logic [BA_W-1:0] ba_o,
  input logic [A_W-1:0]  addr_o,
  input logic            ready_o,
  input logic            rd_ok_o
);
  localparam int MG  = (T_RP > T_MRD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                      : ((T_MRD > T_RFC) ? T_MRD : T_RFC);
  localparam int GW  = $clog2(MG + 2);
  localparam int DW  = $clog2(T_DLL + 1);

  logic [3:0] pins;
  logic is_nop, is_pre, is_ref, is_mrs, is_cmd, is_dllrst;
  assign pins      = {cs_no, ras_no, cas_no, we_no};
  assign is_nop    = (pins == 4'b0111);
  assign is_pre    = (pins == 4'b0010);
  assign is_ref    = (pins == 4'b0001);
  assign is_mrs    = (pins == 4'b0000);
  assign is_cmd    = is_pre || is_ref || is_mrs;
  assign is_dllrst = is_mrs && ba_o == '0 && addr_o[8];

  logic [GW-1:0] gap_q, need_q;
  logic          prev_q;
  logic [DW-1:0] dll_q;
  logic          dll_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; need_q <= '0; prev_q <= 1'b0;
      dll_q <= '0; dll_seen_q <= 1'b0;
    end else begin
      if (is_cmd) begin
        gap_q  <= GW'(1);
        prev_q <= 1'b1;
        need_q <= is_pre ? GW'(T_RP) : is_ref ? GW'(T_RFC) : GW'(T_MRD);
      end else if (gap_q != GW'(MG + 1)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (is_dllrst) begin
        dll_q <= DW'(1); dll_seen_q <= 1'b1;
      end else if (dll_seen_q && dll_q != DW'(T_DLL)) begin
        dll_q <= dll_q + 1'b1;
      end
    end
  end

  // R7
  cmd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && prev_q) |-> gap_q == need_q);
  // R4
  pre_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (addr_o[10] && ba_o == '0));
  // R2
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  // R2
  cke_low_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);
  // R8
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R8
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (is_nop && cke_o));
  // R9
  rd_ok_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok_o |-> (ready_o && dll_seen_q && dll_q == DW'(T_DLL)));
  // R9
  rd_ok_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && dll_seen_q && dll_q == DW'(T_DLL)) |-> rd_ok_o);
endmodule

bind ddr_init_seq ddr_init_chk #(
  .A_W(A_W), .BA_W(BA_W), .T_RP(T_RP), .T_MRD(T_MRD),
  .T_RFC(T_RFC), .T_DLL(T_DLL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o), .cs_no(cs_no),
  .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no), .ba_o(ba_o),
  .addr_o(addr_o), .ready_o(ready_o), .rd_ok_o(rd_ok_o)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
  localparam int         A_W = 12, BA_W = 2;
  localparam int         T_STABLE = 10, T_RP = 3, T_MRD = 2, T_RFC = 7;
  localparam int         N_REF = 3, T_DLL = 60;
  localparam logic [2:0] MR_BL = 3'b010, MR_CL = 3'b011;
  localparam logic       MR_BT = 1'b1, DLL_DIS = 1'b0, DRV_HALF = 1'b1;

  logic clk = 0, rst_n = 0, start = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, rd_ok;
  logic [BA_W-1:0] ba;
  logic [A_W-1:0]  addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddr_init_seq #(
    .A_W(A_W), .BA_W(BA_W), .T_STABLE(T_STABLE), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .N_REF(N_REF), .T_DLL(T_DLL), .MR_BL(MR_BL), .MR_BT(MR_BT),
    .MR_CL(MR_CL), .DLL_DIS(DLL_DIS), .DRV_HALF(DRV_HALF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cke_o(cke), .cs_no(cs_n),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .ba_o(ba), .addr_o(addr),
    .ready_o(ready), .rd_ok_o(rd_ok)
  );

  typedef struct { logic [18:0] bus; string tag; } exp_t;
  exp_t exp_q[$];
  int dll_idx;

  function automatic logic [18:0] mk(logic k, logic [3:0] p, logic [1:0] b, logic [11:0] a);
    return {k, p, b, a};
  endfunction

  task automatic push_cmd(logic [3:0] p, logic [1:0] b, logic [11:0] a, int t, string tg);
    exp_t e;
    e.bus = mk(1, p, b, a); e.tag = tg; exp_q.push_back(e);
    for (int i = 1; i < t; i++) begin
      e.bus = mk(1, 4'b0111, 0, 0); e.tag = "R7"; exp_q.push_back(e);
    end
  endtask

  task automatic build_model();
    exp_t e;
    logic [11:0] mr;
    exp_q.delete();
    for (int i = 0; i < T_STABLE; i++) begin
      e.bus = mk(0, 4'b0111, 0, 0); e.tag = "R2"; exp_q.push_back(e);
    end
    e.bus = mk(1, 4'b0111, 0, 0); e.tag = "R2"; exp_q.push_back(e);
    mr = {5'b0, 1'b0, 1'b0, MR_CL, MR_BT, MR_BL};
    // R3: order of the sequence
    push_cmd(4'b0010, 0, 12'h400, T_RP, "R4");
    push_cmd(4'b0000, 1, {10'b0, DRV_HALF, DLL_DIS}, T_MRD, "R5");
    dll_idx = exp_q.size() + 1;
    push_cmd(4'b0000, 0, mr | 12'h100, T_MRD, "R6");
    push_cmd(4'b0010, 0, 12'h400, T_RP, "R4");
    for (int r = 0; r < N_REF; r++) push_cmd(4'b0001, 0, 0, T_RFC, "R3");
    push_cmd(4'b0000, 0, mr, T_MRD, "R6");
  endtask

  task automatic chk(bit ok, string tg, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tg, act, expv, $time);
    end
  endtask

  function automatic logic [18:0] cur();
    return {cke, cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  // R1 / R10: idle state, start ignored while busy when hold_start=1
  task automatic run_seq(bit hold_start);
    int last, done_idx;
    build_model();
    done_idx = exp_q.size() + 1;
    last = done_idx + T_DLL + 10;
    start = 1;
    @(negedge clk);
    if (!hold_start) start = 0;
    for (int n = 1; n <= last; n++) begin
      logic [18:0] eb;
      bit er, eo;
      string tg;
      if (n < done_idx) begin eb = exp_q[n-1].bus; tg = exp_q[n-1].tag; end
      else begin eb = mk(1, 4'b0111, 0, 0); tg = "R8"; end
      er = (n >= done_idx);
      eo = er && (n - dll_idx >= T_DLL);
      chk(cur() == eb, hold_start ? {tg, " R10"} : tg, 32'(cur()), 32'(eb));
      chk(ready == er, "R8", 32'(ready), 32'(er));
      chk(rd_ok == eo, "R9", 32'(rd_ok), 32'(eo));
      if (!hold_start && (n == 5 || n == done_idx + 3)) start = 1;  // R10
      else if (!hold_start) start = 0;
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic check_idle(string tg);
    chk(cur() == mk(0, 4'b0111, 0, 0), tg, 32'(cur()), 32'(mk(0, 4'b0111, 0, 0)));
    chk({ready, rd_ok} == 2'b00, tg, 32'({ready, rd_ok}), 0);
  endtask

  initial begin
    #1;
    check_idle("R1");
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_idle("R1");
    end
    run_seq(0);
    // reset in the middle of a sequence returns to idle
    start = 1; @(negedge clk); start = 0;
    repeat (T_STABLE + 6) @(negedge clk);
    rst_n = 0; #3;
    check_idle("R1");
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle("R1");
    run_seq(1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule